// File: doc/BRIEF.md
# Prescaled Timer with Overflow Interrupt

This block is a general-purpose timer for a microcontroller-class subsystem. It counts either every cycle of the core clock or edges on an external pin, and can run as an 8-bit or a 16-bit counter. An optional power-of-two divider can sit between the tick source and the counter. When the counter wraps to zero, a sticky flag is set. That flag, gated by an enable bit, drives an interrupt line.

Software reaches the block through a four-address byte bus. Address 0 is the control byte. Address 1 is the counter low byte. Address 2 is the counter high byte. Address 3 holds the flag in bit 0 and the enable in bit 1. The divider's own count is hidden from software. Any counter write clears it while it is in use. A sleep input freezes all counting, so no interrupt can fire while it is high.

Top module: `ptmr_top`

## Requirements
- R1: After reset the control byte reads 0xFF, both counter bytes read 0x00, and address 3 reads 0x00 (flag and enable clear), so `irq_o` is low.
- R2: The control byte fields are: bit 7 run, bit 6 8-bit mode (1 = 8-bit), bit 5 source (1 = external pin, 0 = core clock), bit 4 pin edge (0 = rising, 1 = falling), bit 3 divider bypass (1 = bypassed), bits 2:0 ratio code. A written value reads back unchanged.
- R3: With bypass at 1, the counter advances by one on every source tick. The core clock source gives one tick per cycle.
- R4: With bypass at 0, the counter advances once per 2^(code+1) source ticks, for divides of 2 up to 256. A new ratio or bypass setting takes effect without a reset.
- R5: While bypass is 0, any write to address 1 or 2 clears the hidden divider count. Such a write leaves the control byte unchanged.
- R6: In 8-bit mode only the low byte counts. A wrap from 0xFF to 0x00 sets the flag, and the high byte keeps its value. A low-byte write loads only the low byte, and a high-byte read returns the live high byte.
- R7: In 16-bit mode the wrap from 0xFFFF to 0x0000 sets the flag. A low-byte read copies the live high byte into a buffer, and address 2 then returns that buffer. A high-byte write only fills a buffer, which is loaded into the counter by the next low-byte write.
- R8: The flag stays set until software writes 0 to bit 0 of address 3. `irq_o` is high exactly when both the flag and the enable are 1.
- R9: The external pin passes through a two-stage synchronizer. Each selected edge then counts as one source tick.
- R10: While `sleep_i` is high, neither the counter nor the divider advances, and the flag cannot be set.
- R11: While the run bit is 0, the counter and the divider hold their values, and pin edges are ignored.
- R12: When a low-byte write and an advance fall in the same cycle, the written value is loaded and the flag is not set, even if the advance would have wrapped the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock; also the internal tick source |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_i | input | 1 | Freezes counting while high |
| ext_pin_i | input | 1 | Asynchronous external count input |
| bus_we_i | input | 1 | Register write strobe |
| bus_re_i | input | 1 | Register read strobe (used for the high-byte snapshot) |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the addressed register |
| irq_o | output | 1 | Interrupt request, flag AND enable |

## Verification
The hardest case to reach is a low-byte write that lands on the exact cycle where the counter wraps. The write must win, and no flag may appear. The bench reaches it by stopping the timer at 0xFF, starting it with one control write, and writing the low byte on the very next bus cycle. The hidden divider clear cannot be seen directly, so the stimulus leaves the divider one tick short of rolling over, writes the counter, and shows that the next few ticks do not produce the increment that a stale count would have caused.

// File: rtl/ptmr_pkg.sv
`timescale 1ns/1ps
package ptmr_pkg;

  typedef struct packed {
    logic       run;
    logic       mode8;
    logic       ext_src;
    logic       fall_edge;
    logic       bypass;
    logic [2:0] ratio;
  } ctrl_t;

  localparam logic [7:0] CTRL_RESET = 8'hFF;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_CLO  = 2'd1,
    A_CHI  = 2'd2,
    A_IRQ  = 2'd3
  } addr_e;

  // Low-bit mask for a divide of 2^(code+1): all ones means the next tick passes.
  function automatic logic [15:0] ratio_mask(input logic [2:0] code);
    return (16'd2 << code) - 16'd1;
  endfunction

  // Increment respecting the active width; the high byte is frozen in 8-bit mode.
  function automatic logic [15:0] bump(input logic [15:0] v, input logic mode8);
    logic [7:0] lo;
    lo = v[7:0] + 8'd1;
    return mode8 ? {v[15:8], lo} : v + 16'd1;
  endfunction

  function automatic logic at_top(input logic [15:0] v, input logic mode8);
    return mode8 ? (v[7:0] == 8'hFF) : (v == 16'hFFFF);
  endfunction

endpackage

// File: rtl/ptmr_sync_edge.sv
`timescale 1ns/1ps
module ptmr_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic fall_i,
  output logic tick_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              cur;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= pin_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], pin_i};
      end
    end
  endgenerate

  assign cur = sync_q[STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= cur;
  end

  assign tick_o = fall_i ? (prev_q & ~cur) : (~prev_q & cur);
endmodule

// File: rtl/ptmr_presc.sv
`timescale 1ns/1ps
module ptmr_presc
  import ptmr_pkg::*;
#(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             src_tick_i,
  input  logic             bypass_i,
  input  logic [2:0]       ratio_i,
  input  logic             clr_i,
  output logic             tick_o,
  output logic [PRE_W-1:0] level_o
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] mask;
  logic             full;
  logic             step;

  assign mask   = ratio_mask(ratio_i)[PRE_W-1:0];
  assign full   = (cnt_q & mask) == mask;
  assign step   = run_i & src_tick_i;
  assign tick_o = step & (bypass_i | full);
  assign level_o = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (step && !bypass_i) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ptmr_count.sv
`timescale 1ns/1ps
module ptmr_count
  import ptmr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode8_i,
  input  logic        adv_i,
  input  logic        ld_lo_i,
  input  logic        ld_hi_i,
  input  logic        rd_lo_i,
  input  logic [7:0]  wdata_i,
  output logic [15:0] cnt_o,
  output logic [7:0]  hi_view_o,
  output logic        ovf_o
);
  logic [15:0] cnt_q;
  logic [7:0]  wr_buf_q;
  logic [7:0]  rd_buf_q;

  assign ovf_o     = adv_i & ~ld_lo_i & at_top(cnt_q, mode8_i);
  assign cnt_o     = cnt_q;
  assign hi_view_o = mode8_i ? cnt_q[15:8] : rd_buf_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (ld_lo_i) cnt_q <= mode8_i ? {cnt_q[15:8], wdata_i} : {wr_buf_q, wdata_i};
    else if (adv_i)   cnt_q <= bump(cnt_q, mode8_i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_buf_q <= '0;
      rd_buf_q <= '0;
    end else begin
      if (ld_hi_i) wr_buf_q <= wdata_i;
      if (rd_lo_i) rd_buf_q <= cnt_q[15:8];
    end
  end
endmodule

// File: rtl/ptmr_top.sv
`timescale 1ns/1ps
module ptmr_top
  import ptmr_pkg::*;
#(
  parameter int PRE_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_i,
  input  logic       ext_pin_i,
  input  logic       bus_we_i,
  input  logic       bus_re_i,
  input  logic [1:0] bus_addr_i,
  input  logic [7:0] bus_wdata_i,
  output logic [7:0] bus_rdata_o,
  output logic       irq_o
);
  ctrl_t            ctrl_q;
  logic             flag_q;
  logic             en_q;

  // Named internal events
  logic             ld_lo, ld_hi, rd_lo, wr_ctrl, wr_irq;
  logic             presc_clr;
  logic             run;
  logic             ext_tick, src_tick, adv;
  logic             ovf;
  logic [15:0]      cnt;
  logic [7:0]       hi_view;
  logic [PRE_W-1:0] presc_lvl;

  assign wr_ctrl   = bus_we_i && (bus_addr_i == A_CTRL);
  assign ld_lo     = bus_we_i && (bus_addr_i == A_CLO);
  assign ld_hi     = bus_we_i && (bus_addr_i == A_CHI);
  assign wr_irq    = bus_we_i && (bus_addr_i == A_IRQ);
  assign rd_lo     = bus_re_i && (bus_addr_i == A_CLO);
  assign presc_clr = (ld_lo | ld_hi) & ~ctrl_q.bypass;
  assign run       = ctrl_q.run & ~sleep_i;
  assign src_tick  = ctrl_q.ext_src ? ext_tick : 1'b1;

  ptmr_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (ext_pin_i),
    .fall_i (ctrl_q.fall_edge),
    .tick_o (ext_tick)
  );

  ptmr_presc #(.PRE_W(PRE_W)) u_presc (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (run),
    .src_tick_i (src_tick),
    .bypass_i   (ctrl_q.bypass),
    .ratio_i    (ctrl_q.ratio),
    .clr_i      (presc_clr),
    .tick_o     (adv),
    .level_o    (presc_lvl)
  );

  ptmr_count u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode8_i   (ctrl_q.mode8),
    .adv_i     (adv),
    .ld_lo_i   (ld_lo),
    .ld_hi_i   (ld_hi),
    .rd_lo_i   (rd_lo),
    .wdata_i   (bus_wdata_i),
    .cnt_o     (cnt),
    .hi_view_o (hi_view),
    .ovf_o     (ovf)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= ctrl_t'(CTRL_RESET);
      flag_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata_i);
      if (ovf)         flag_q <= 1'b1;
      else if (wr_irq) flag_q <= bus_wdata_i[0];
      if (wr_irq)  en_q <= bus_wdata_i[1];
    end
  end

  always_comb begin
    unique case (bus_addr_i)
      A_CTRL:  bus_rdata_o = ctrl_q;
      A_CLO:   bus_rdata_o = cnt[7:0];
      A_CHI:   bus_rdata_o = hi_view;
      default: bus_rdata_o = {6'd0, en_q, flag_q};
    endcase
  end

  assign irq_o = flag_q & en_q;
endmodule

// File: rtl/ptmr_chk.sv
`timescale 1ns/1ps
module ptmr_chk
  import ptmr_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        sleep_i,
  input ctrl_t       ctrl,
  input logic [15:0] cnt,
  input logic [7:0]  presc,
  input logic        flag,
  input logic        ovf,
  input logic        ld_lo,
  input logic        presc_clr,
  input logic        src_tick,
  input logic        bus_we_i,
  input logic [1:0]  bus_addr_i,
  input logic [7:0]  bus_wdata_i
);
  logic sw_flag_wr;
  assign sw_flag_wr = bus_we_i && (bus_addr_i == 2'd3);

  a_r3_bypass_steps: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.run && ctrl.bypass && !sleep_i && src_tick && !ld_lo |=> cnt != $past(cnt));

  a_r5_presc_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    presc_clr |=> presc == 8'd0);

  a_r6_wrap8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && ctrl.mode8 |=> cnt[7:0] == 8'd0 && $stable(cnt[15:8]));

  a_r7_wrap16: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !ctrl.mode8 |=> cnt == 16'd0);

  a_r8_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> flag);

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !sw_flag_wr |=> flag);

  a_r10_sleep_cnt: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i && !ld_lo |=> $stable(cnt));

  a_r10_sleep_presc: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i && !presc_clr |=> $stable(presc));

  a_r11_off_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.run && !ld_lo |=> $stable(cnt));

  a_r12_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ld_lo |=> cnt[7:0] == $past(bus_wdata_i));

  a_r12_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ld_lo && !flag && !sw_flag_wr |=> !flag);
endmodule

bind ptmr_top ptmr_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .sleep_i     (sleep_i),
  .ctrl        (ctrl_q),
  .cnt         (cnt),
  .presc       (presc_lvl),
  .flag        (flag_q),
  .ovf         (ovf),
  .ld_lo       (ld_lo),
  .presc_clr   (presc_clr),
  .src_tick    (src_tick),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i)
);

// File: tb/ptmr_top_tb_top.sv
`timescale 1ns/1ps
module ptmr_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sleep_i = 1'b0;
  logic       ext_pin_i = 1'b0;
  logic       bus_we_i = 1'b0;
  logic       bus_re_i = 1'b0;
  logic [1:0] bus_addr_i = 2'd0;
  logic [7:0] bus_wdata_i = 8'd0;
  logic [7:0] bus_rdata_o;
  logic       irq_o;

  int n_vec = 0;
  int n_bad = 0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb_q[$];

  always #2.5 clk = ~clk;

  ptmr_top dut_i (
    .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .ext_pin_i(ext_pin_i),
    .bus_we_i(bus_we_i), .bus_re_i(bus_re_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .irq_o(irq_o)
  );

  // Monitor: pops one expected item per read strobe.
  always @(negedge clk) begin
    #1;
    if (bus_re_i && sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_vec++;
      if (bus_rdata_o !== it.exp) begin
        n_bad++;
        $display("FAIL %s: read addr %0d got 0x%02h expected 0x%02h",
                 it.tag, bus_addr_i, bus_rdata_o, it.exp);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk);
    bus_we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    bus_re_i = 1'b1; bus_addr_i = a;
    @(negedge clk);
    bus_re_i = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    n_vec++;
    if (irq_o !== e) begin
      n_bad++;
      $display("FAIL %s: irq_o got %b expected %b", tag, irq_o, e);
    end
  endtask

  // Start with ctrl_on, leave it on for n counted edges, then clear the run bit.
  task automatic run(input logic [7:0] ctrl_on, input int n);
    wr(2'd0, ctrl_on);
    if (n > 1) idle(n - 1);
    wr(2'd0, ctrl_on & 8'h7F);
  endtask

  task automatic pulses(input int k);
    for (int i = 0; i < k; i++) begin
      ext_pin_i = 1'b1; idle(4);
      ext_pin_i = 1'b0; idle(4);
    end
  endtask

  function automatic logic [7:0] divided(input int ticks, input int code);
    return 8'(ticks / (1 << (code + 1)));
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, got hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    rd(2'd0, 8'hFF, "R1 ctrl");
    rd(2'd1, 8'h00, "R1 lo");
    rd(2'd2, 8'h00, "R1 hi");
    rd(2'd3, 8'h00, "R1 irq reg");
    chk_irq(1'b0, "R1 irq");

    // R2 / R3: 8-bit, core clock, bypass
    wr(2'd0, 8'h48);
    rd(2'd0, 8'h48, "R2 readback");
    run(8'hC8, 10);
    rd(2'd1, 8'd10, "R3 ten ticks");
    idle(5);
    rd(2'd1, 8'd10, "R11 held while off");

    // R6: 8-bit wrap keeps high byte
    wr(2'd0, 8'h08); wr(2'd2, 8'h12); wr(2'd1, 8'hFD);
    rd(2'd1, 8'hFD, "R7 load lo");
    rd(2'd2, 8'h12, "R7 load hi");
    wr(2'd0, 8'h48);
    run(8'hC8, 4);
    rd(2'd1, 8'h01, "R6 wrap lo");
    rd(2'd2, 8'h12, "R6 hi held");
    rd(2'd3, 8'h01, "R6 flag set");
    chk_irq(1'b0, "R8 masked");
    wr(2'd3, 8'h03);
    chk_irq(1'b1, "R8 enabled");
    idle(3);
    rd(2'd3, 8'h03, "R8 sticky");
    wr(2'd3, 8'h02);
    chk_irq(1'b0, "R8 cleared");

    // R7: 16-bit wrap, snapshot and write buffer
    wr(2'd0, 8'h08); wr(2'd2, 8'hFF); wr(2'd1, 8'hFE);
    run(8'h88, 3);
    rd(2'd1, 8'h01, "R7 wrap lo");
    rd(2'd2, 8'h00, "R7 wrap hi");
    rd(2'd3, 8'h03, "R7 flag");
    chk_irq(1'b1, "R8 irq on wrap");
    wr(2'd3, 8'h02);
    wr(2'd2, 8'h00); wr(2'd1, 8'hFF);
    rd(2'd1, 8'hFF, "R7 pre lo");
    run(8'h88, 1);
    rd(2'd2, 8'h00, "R7 snapshot kept");
    rd(2'd1, 8'h00, "R7 new lo");
    rd(2'd2, 8'h01, "R7 new snapshot");
    wr(2'd2, 8'h55);
    rd(2'd1, 8'h00, "R7 hi write buffered lo");
    rd(2'd2, 8'h01, "R7 hi write buffered hi");
    wr(2'd1, 8'h66);
    rd(2'd1, 8'h66, "R7 pair lo");
    rd(2'd2, 8'h55, "R7 pair hi");

    // R4: divider ratios, changed on the fly
    wr(2'd0, 8'h40); wr(2'd1, 8'h00);
    run(8'hC0, 8);
    rd(2'd1, divided(8, 0), "R4 div2");
    wr(2'd0, 8'h42); wr(2'd1, 8'h00);
    run(8'hC2, 20);
    rd(2'd1, divided(20, 2), "R4 div8");
    wr(2'd0, 8'h47); wr(2'd1, 8'h00);
    run(8'hC7, 600);
    rd(2'd1, divided(600, 7), "R4 div256");

    // R5: counter write clears hidden divider
    wr(2'd0, 8'h41); wr(2'd1, 8'h00);
    run(8'hC1, 3);
    rd(2'd1, 8'h00, "R5 no tick yet");
    wr(2'd1, 8'h10);
    run(8'hC1, 3);
    rd(2'd1, 8'h10, "R5 divider cleared");
    run(8'hC1, 1);
    rd(2'd1, 8'h11, "R5 fourth tick");
    rd(2'd0, 8'h41, "R5 ctrl unchanged");

    // R9: external pin, rising then falling
    wr(2'd0, 8'h68); wr(2'd1, 8'h00);
    wr(2'd0, 8'hE8);
    pulses(3); idle(6);
    wr(2'd0, 8'h68);
    rd(2'd1, 8'd3, "R9 rising");
    wr(2'd0, 8'h78); wr(2'd1, 8'h00);
    wr(2'd0, 8'hF8);
    pulses(2); idle(6);
    wr(2'd0, 8'h78);
    rd(2'd1, 8'd2, "R9 falling");
    pulses(2); idle(6);
    rd(2'd1, 8'd2, "R11 pin ignored while off");

    // R10: sleep freezes
    wr(2'd0, 8'h48); wr(2'd1, 8'hFE); wr(2'd3, 8'h02);
    sleep_i = 1'b1;
    run(8'hC8, 10);
    sleep_i = 1'b0;
    rd(2'd1, 8'hFE, "R10 count frozen");
    rd(2'd3, 8'h02, "R10 no flag");

    // R12: write collides with wrap
    wr(2'd1, 8'hFF);
    wr(2'd0, 8'hC8);
    wr(2'd1, 8'h40);
    wr(2'd0, 8'h48);
    rd(2'd1, 8'h41, "R12 write wins");
    rd(2'd3, 8'h02, "R12 no flag");

    idle(3);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule